// File: doc/BRIEF.md
# Masked Interrupt Status Unit

This block keeps the interrupt state of a serial port. It holds a raw status register whose bits are set by hardware events, a mask register that software writes, the masked status, and one interrupt line. The transmit path pulses a set input each time a character is written to the data register. The receive path pulses a set input when the FIFO fill reaches its trigger level. It raises a level-clear request when the fill drops to one below that level.

Software clears raw bits by writing ones to a clear port. Bits written as zero are left alone. The interrupt line is high whenever any raw bit is high under a set mask bit. Only two raw bit positions have event sources. The others always read zero, but their mask bits still store whatever software writes.

Top module: `irq_status_unit`

## Requirements
- R1: After asynchronous reset, raw_o, mask_o and masked_o are all zero and irq_o is low.
- R2: A cycle with tx_set_i high makes raw_o bit 5 (transmit) read one from the next cycle on.
- R3: A cycle with rx_set_i high makes raw_o bit 4 (receive) read one from the next cycle on.
- R4: A cycle with clr_we_i high clears every raw bit for which clr_wdata_i holds a one, from the next cycle on. Raw bits whose clr_wdata_i bit is zero keep their value.
- R5: A cycle with rx_clr_i high clears raw_o bit 4 from the next cycle on. It has no effect on bit 5, which is checked at raw_o.
- R6: When a set event and any clear of the same bit (clear port or rx_clr_i) fall in the same cycle, the bit reads one afterwards.
- R7: masked_o equals raw_o AND mask_o, and irq_o is high exactly when masked_o is non-zero. Both follow the registered state in the same cycle it changes, so a mask write acts on irq_o from the next cycle.
- R8: A cycle with mask_we_i high loads all W bits of mask_wdata_i into mask_o from the next cycle on. Raw bits other than 4 and 5 always read zero.
- R9: In a cycle with no set, clear or level-clear input, raw_o keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_set_i | input | 1 | Pulse on a data-register write; sets the transmit bit |
| rx_set_i | input | 1 | Pulse when the receive fill reaches the trigger level |
| rx_clr_i | input | 1 | Pulse when the receive fill drops below the trigger level |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | W | Mask write value |
| clr_we_i | input | 1 | Clear-register write strobe |
| clr_wdata_i | input | W | Clear value; one bits clear raw bits |
| raw_o | output | W | Raw status |
| mask_o | output | W | Mask register |
| masked_o | output | W | Raw status AND mask |
| irq_o | output | 1 | OR of the masked status |

## Verification
Every raw and mask update is due one clock edge after the cycle that carries its strobe. masked_o and irq_o follow combinationally from those registers, so they are due at that same edge, with no extra delay. The bench drives inputs a quarter period after a rising edge, applies them at the next rising edge, and then compares all outputs a quarter period later. Its model is therefore stepped exactly once per edge.

// File: rtl/isu_pkg.sv
package isu_pkg;
  localparam int unsigned ISU_W      = 8;
  localparam int unsigned ISU_RX_BIT = 4;
  localparam int unsigned ISU_TX_BIT = 5;
endpackage

// File: rtl/isu_status_bit.sv
module isu_status_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/isu_mask_reg.sv
module isu_mask_reg #(
  parameter int unsigned W = isu_pkg::ISU_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= wdata_i;
  end
endmodule

// File: rtl/isu_combine.sv
module isu_combine #(
  parameter int unsigned W = isu_pkg::ISU_W
) (
  input  logic [W-1:0] raw_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] masked_o,
  output logic         irq_o
);
  always_comb begin
    masked_o = raw_i & mask_i;
    irq_o    = |masked_o;
  end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit #(
  parameter int unsigned W      = isu_pkg::ISU_W,
  parameter int unsigned RX_BIT = isu_pkg::ISU_RX_BIT,
  parameter int unsigned TX_BIT = isu_pkg::ISU_TX_BIT
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tx_set_i,
  input  logic         rx_set_i,
  input  logic         rx_clr_i,
  input  logic         mask_we_i,
  input  logic [W-1:0] mask_wdata_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] clr_wdata_i,
  output logic [W-1:0] raw_o,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] masked_o,
  output logic         irq_o
);
  logic [W-1:0] set_vec;
  logic [W-1:0] clr_vec;

  always_comb begin
    set_vec         = '0;
    set_vec[TX_BIT] = tx_set_i;
    set_vec[RX_BIT] = rx_set_i;
    clr_vec         = clr_we_i ? clr_wdata_i : '0;
    clr_vec[RX_BIT] = clr_vec[RX_BIT] | rx_clr_i;
  end

  // bits without a source have set tied low and stay zero
  for (genvar i = 0; i < W; i++) begin : g_bit
    isu_status_bit u_bit (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_vec[i]),
      .clr_i  (clr_vec[i]),
      .q_o    (raw_o[i])
    );
  end

  isu_mask_reg #(.W(W)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mask_we_i),
    .wdata_i (mask_wdata_i),
    .q_o     (mask_o)
  );

  isu_combine #(.W(W)) u_comb (
    .raw_i    (raw_o),
    .mask_i   (mask_o),
    .masked_o (masked_o),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/isu_checker.sv
module isu_checker #(
  parameter int unsigned W      = isu_pkg::ISU_W,
  parameter int unsigned RX_BIT = isu_pkg::ISU_RX_BIT,
  parameter int unsigned TX_BIT = isu_pkg::ISU_TX_BIT
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         tx_set_i,
  input logic         rx_set_i,
  input logic         rx_clr_i,
  input logic         mask_we_i,
  input logic [W-1:0] mask_wdata_i,
  input logic         clr_we_i,
  input logic [W-1:0] clr_wdata_i,
  input logic [W-1:0] raw_o,
  input logic [W-1:0] mask_o,
  input logic [W-1:0] masked_o,
  input logic         irq_o
);
  a_r2_tx_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_set_i |=> raw_o[TX_BIT]);

  a_r3_rx_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_set_i |=> raw_o[RX_BIT]);

  a_r4_w1c_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && clr_wdata_i[TX_BIT] && !tx_set_i) |=> !raw_o[TX_BIT]);

  a_r5_hw_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_clr_i && !rx_set_i) |=> !raw_o[RX_BIT]);

  a_r7_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (masked_o == (raw_o & mask_o)) && (irq_o == (masked_o != '0)));

  a_r8_mask_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we_i |=> (mask_o == $past(mask_wdata_i)));

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_set_i && !rx_set_i && !rx_clr_i && !clr_we_i) |=> $stable(raw_o));
endmodule

bind irq_status_unit isu_checker #(.W(W), .RX_BIT(RX_BIT), .TX_BIT(TX_BIT)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tx_set_i     (tx_set_i),
  .rx_set_i     (rx_set_i),
  .rx_clr_i     (rx_clr_i),
  .mask_we_i    (mask_we_i),
  .mask_wdata_i (mask_wdata_i),
  .clr_we_i     (clr_we_i),
  .clr_wdata_i  (clr_wdata_i),
  .raw_o        (raw_o),
  .mask_o       (mask_o),
  .masked_o     (masked_o),
  .irq_o        (irq_o)
);

// File: tb/sim_irq_status_unit.sv
`timescale 1ns/1ps
module sim_irq_status_unit;
  localparam int W   = 8;
  localparam int RXB = 4;
  localparam int TXB = 5;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tx_set = 1'b0, rx_set = 1'b0, rx_clr = 1'b0;
  logic         mask_we = 1'b0, clr_we = 1'b0;
  logic [W-1:0] mask_wdata = '0, clr_wdata = '0;
  logic [W-1:0] raw, mask, masked;
  logic         irq;

  logic [W-1:0] exp_raw = '0, exp_mask = '0;
  int vectors = 0;
  int errors  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_unit #(.W(W), .RX_BIT(RXB), .TX_BIT(TXB)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_set_i(tx_set), .rx_set_i(rx_set), .rx_clr_i(rx_clr),
    .mask_we_i(mask_we), .mask_wdata_i(mask_wdata),
    .clr_we_i(clr_we), .clr_wdata_i(clr_wdata),
    .raw_o(raw), .mask_o(mask), .masked_o(masked), .irq_o(irq)
  );

  task automatic check(input string tag);
    logic [W-1:0] em;
    em = exp_raw & exp_mask;
    vectors++;
    if (raw !== exp_raw || mask !== exp_mask || masked !== em || irq !== (em != '0)) begin
      errors++;
      if (raw !== exp_raw)
        $display("FAIL %s raw (R2/R3/R4/R5/R6/R8/R9): got %h exp %h", tag, raw, exp_raw);
      if (mask !== exp_mask)
        $display("FAIL %s R8 mask: got %h exp %h", tag, mask, exp_mask);
      if (masked !== em)
        $display("FAIL %s R7 masked: got %h exp %h", tag, masked, em);
      if (irq !== (em != '0))
        $display("FAIL %s R7 irq: got %b exp %b", tag, irq, (em != '0));
    end
  endtask

  // one edge: model steps from the requirements, then outputs compared
  task automatic step(input string tag);
    logic [W-1:0] n;
    n = exp_raw;
    if (clr_we) n = n & ~clr_wdata;       // R4
    if (rx_clr) n[RXB] = 1'b0;            // R5
    if (tx_set) n[TXB] = 1'b1;            // R2, R6
    if (rx_set) n[RXB] = 1'b1;            // R3, R6
    if (mask_we) exp_mask = mask_wdata;   // R8
    @(posedge clk);
    exp_raw = n;
    #(CLK_PERIOD/4);
    check(tag);
    tx_set = 0; rx_set = 0; rx_clr = 0; mask_we = 0; clr_we = 0;
    mask_wdata = '0; clr_wdata = '0;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    $display("FAIL watchdog expired");
    errors++;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*2 + CLK_PERIOD/4);
    check("R1_reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #(CLK_PERIOD/4);
    check("R1_after_release");

    // full mask so R7 sees every raw bit
    mask_we = 1; mask_wdata = '1;
    step("R8_mask_all");

    // every start state x every combination of events and clear bits
    for (int s = 0; s < 4; s++) begin
      for (int v = 0; v < 64; v++) begin
        clr_we = 1; clr_wdata = '1;
        step("R4_clear_all");
        rx_set = s[0]; tx_set = s[1];
        step("R2_R3_preset");
        tx_set = v[0]; rx_set = v[1]; rx_clr = v[2];
        clr_we = v[3];
        clr_wdata = {W{v[3]}};
        clr_wdata[RXB] = v[4];
        clr_wdata[TXB] = v[5];
        step("R6_sweep");
        step("R9_idle");
      end
    end

    // every mask value against two raw states
    for (int r = 0; r < 2; r++) begin
      clr_we = 1; clr_wdata = '1;
      tx_set = 1; rx_set = r[0];
      step("R6_set_with_clear");
      for (int m = 0; m < (1 << W); m++) begin
        mask_we = 1; mask_wdata = m[W-1:0];
        step("R7_mask_sweep");
      end
    end

    // rx level clear leaves tx bit alone
    tx_set = 1; rx_set = 1;
    step("R2_R3_both");
    rx_clr = 1;
    step("R5_hw_clear");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule